// File: doc/BRIEF.md
# NAND Spare-Area ECC Packer and Bad-Block Checker

This block sits between a page buffer and a NAND flash bus engine. On a page program, the page data streams in one byte per accepted cycle. A single shared ECC engine works through the page in 256-byte chunks and keeps three check bytes for each chunk. As soon as the last data byte has been taken, the block emits the whole spare area. The check bytes sit at fixed spare offsets that depend on the page geometry, and every other spare byte is 0xFF.

On a bad-block scan, the host streams the spare bytes of page 0 of a block and then those of page 1. The block applies the marker rule for the selected geometry. It reports a single verdict pulse. That pulse comes right after page 0 when page 0 already fails, and otherwise right after page 1. Two geometries are supported: a 512-byte page with a 16-byte spare, and a 2048-byte page with a 64-byte spare. The geometry is sampled from `page_big` when each operation starts.

Top module: `spare_ecc_packer`

## Requirements
- R1: For each 256-byte chunk d[0..255], the ECC is computed as follows. C[5:0] is the XOR over all bytes of column bits, where C bits 0..5 are the XOR of byte bits {0,2,4,6}, {1,3,5,7}, {0,1,4,5}, {2,3,6,7}, {0,1,2,3} and {4,5,6,7}. L is the XOR of the index i over the bytes with odd bit parity. M is the XOR of ~i over those same bytes. ECC byte 0 = ~{L7,M7,L6,M6,L5,M5,L4,M4}, byte 1 = ~{L3,M3,L2,M2,L1,M1,L0,M0}, byte 2 = {~C[5:0],2'b11}.
- R2: With `page_big`=0 (512-byte page, 16-byte spare), ECC bytes 0..2 of chunk 0 and then 0..2 of chunk 1 appear at spare offsets 0, 1, 2, 3, 6 and 7 in that order. All other spare bytes are 0xFF.
- R3: With `page_big`=1 (2048-byte page, 64-byte spare), the 24 ECC bytes (chunk 0 first, three bytes per chunk) appear at spare offsets 40..63. Offsets 0..39 are 0xFF.
- R4: Spare byte k is driven on `spr_data` with `spr_valid` high in the (k+1)-th cycle after the clock edge that accepts the last data byte. The spare bytes come on consecutive cycles, `spr_last` marks the final one, and `spr_valid` is low while data is still being taken.
- R5: `prg_valid` has no effect outside the data phase. This covers bytes offered before `prg_start` and bytes offered while the spare area is being emitted.
- R6: With a 16-byte spare, a page fails when spare byte 5 is not 0xFF. Other bytes do not affect the verdict.
- R7: With a 64-byte spare, a page fails only when spare bytes 0 and 1 are both not 0xFF. A single non-0xFF byte among them leaves the page good.
- R8: If page 0 fails, the verdict (`res_bad`=1, `res_page`=0) is issued after page 0, and the page 1 bytes that follow are ignored. Otherwise the verdict is issued after page 1 with `res_page`=1 and `res_bad` set to the page 1 result.
- R9: `res_valid` is a one-cycle pulse, due in the cycle right after the clock edge that accepts the deciding page's last spare byte.
- R10: After reset, `spr_valid` and `res_valid` are low.
- R11: `chk_valid` bytes offered when no scan has been started cause no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_big | input | 1 | Geometry select: 0 = 512+16, 1 = 2048+64; sampled at start |
| prg_start | input | 1 | Starts a page program (taken when idle) |
| prg_valid | input | 1 | Data byte strobe |
| prg_data | input | 8 | Page data byte |
| spr_valid | output | 1 | Spare byte valid |
| spr_data | output | 8 | Spare byte |
| spr_last | output | 1 | Final spare byte |
| chk_start | input | 1 | Starts a bad-block scan at page 0 |
| chk_valid | input | 1 | Spare byte strobe for the scan |
| chk_data | input | 8 | Spare byte read from flash |
| res_valid | output | 1 | Verdict pulse |
| res_bad | output | 1 | Block is bad |
| res_page | output | 1 | Page that decided the verdict |

## Verification
Spare byte k is due k+1 cycles after the edge that takes the last data byte. The verdict is due exactly one cycle after the edge that takes the deciding page's last spare byte. Inputs are driven and outputs sampled on the falling edge. Each check therefore reads the cycle where the result must first appear, and the bench also confirms the output was absent one cycle earlier and is gone one cycle later. Random pages with random idle gaps show that the timing is counted from accepted bytes and not from elapsed cycles.

// File: rtl/spe_pkg.sv
package spe_pkg;
  localparam int CHUNK_BYTES = 256;
  typedef logic [2:0][7:0] ecc_t;

  // bit 6: parity of the byte, bits 5:0: column parities
  function automatic logic [6:0] col_par(input logic [7:0] b);
    logic [6:0] r;
    r[0] = b[0] ^ b[2] ^ b[4] ^ b[6];
    r[1] = b[1] ^ b[3] ^ b[5] ^ b[7];
    r[2] = b[0] ^ b[1] ^ b[4] ^ b[5];
    r[3] = b[2] ^ b[3] ^ b[6] ^ b[7];
    r[4] = ^b[3:0];
    r[5] = ^b[7:4];
    r[6] = ^b;
    return r;
  endfunction

  function automatic ecc_t ecc_pack(input logic [7:0] lp, input logic [7:0] lm,
                                    input logic [5:0] cp);
    ecc_t e;
    for (int k = 0; k < 4; k++) begin
      e[0][2*k+1] = ~lp[k+4];
      e[0][2*k]   = ~lm[k+4];
      e[1][2*k+1] = ~lp[k];
      e[1][2*k]   = ~lm[k];
    end
    e[2] = {~cp, 2'b11};
    return e;
  endfunction
endpackage

// File: rtl/spe_ecc_chunk.sv
module spe_ecc_chunk
  import spe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  input  logic [7:0] pos,
  output ecc_t       ecc_o
);
  logic [5:0] cp_q, cp_d;
  logic [7:0] lp_q, lp_d, lm_q, lm_d;
  logic [6:0] cpar;

  always_comb begin
    cpar = col_par(din);
    cp_d = cp_q ^ cpar[5:0];
    lp_d = lp_q;
    lm_d = lm_q;
    if (cpar[6]) begin
      lp_d = lp_q ^ pos;
      lm_d = lm_q ^ ~pos;
    end
    ecc_o = ecc_pack(lp_d, lm_d, cp_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_q <= '0;
      lp_q <= '0;
      lm_q <= '0;
    end else if (clr) begin
      cp_q <= '0;
      lp_q <= '0;
      lm_q <= '0;
    end else if (en) begin
      if (pos == 8'hFF) begin
        cp_q <= '0;
        lp_q <= '0;
        lm_q <= '0;
      end else begin
        cp_q <= cp_d;
        lp_q <= lp_d;
        lm_q <= lm_d;
      end
    end
  end
endmodule

// File: rtl/spe_spare_map.sv
module spe_spare_map #(
  parameter int SLOTS     = 8,
  parameter int BIG_SPARE = 64
) (
  input  logic                  big,
  input  logic [5:0]            sidx,
  input  logic [SLOTS*24-1:0]   ecc_flat,
  output logic [7:0]            byte_o
);
  localparam logic [5:0] BIG_BASE = 6'(BIG_SPARE - 3 * SLOTS);

  logic [5:0] j;

  always_comb begin
    byte_o = 8'hFF;
    j      = '0;
    if (!big) begin
      if (sidx < 6'd4) begin
        j      = sidx;
        byte_o = ecc_flat[{j, 3'b000} +: 8];
      end else if (sidx == 6'd6 || sidx == 6'd7) begin
        j      = sidx - 6'd2;
        byte_o = ecc_flat[{j, 3'b000} +: 8];
      end
    end else if (sidx >= BIG_BASE) begin
      j      = sidx - BIG_BASE;
      byte_o = ecc_flat[{j, 3'b000} +: 8];
    end
  end
endmodule

// File: rtl/spe_bad_check.sv
module spe_bad_check #(
  parameter int SMALL_SPARE = 16,
  parameter int BIG_SPARE   = 64,
  parameter int SMALL_MARK  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       page_big,
  input  logic       chk_start,
  input  logic       chk_valid,
  input  logic [7:0] chk_data,
  output logic       res_valid,
  output logic       res_bad,
  output logic       res_page
);
  localparam int SW = $clog2(BIG_SPARE);
  localparam logic [SW-1:0] SMALL_END = SW'(SMALL_SPARE - 1);
  localparam logic [SW-1:0] BIG_END   = SW'(BIG_SPARE - 1);
  localparam logic [SW-1:0] MARK_POS  = SW'(SMALL_MARK);

  typedef enum logic {C_IDLE, C_RUN} cst_t;

  cst_t          st_q, st_d;
  logic          big_q, big_d, pg_q, pg_d, m0_q, m0_d, bad_q, bad_d;
  logic [SW-1:0] cnt_q, cnt_d;
  logic          rv_q, rv_d, rb_q, rb_d, rp_q, rp_d;
  logic          last, nonff, hit_now, page_bad;

  always_comb begin
    last     = cnt_q == (big_q ? BIG_END : SMALL_END);
    nonff    = chk_data != 8'hFF;
    hit_now  = big_q ? (cnt_q == SW'(1) && m0_q && nonff)
                     : (cnt_q == MARK_POS && nonff);
    page_bad = bad_q | hit_now;

    st_d  = st_q;  big_d = big_q; pg_d = pg_q; m0_d = m0_q;
    bad_d = bad_q; cnt_d = cnt_q;
    rv_d  = 1'b0;  rb_d  = rb_q;  rp_d = rp_q;

    if (chk_start) begin
      st_d  = C_RUN;
      big_d = page_big;
      pg_d  = 1'b0;
      cnt_d = '0;
      m0_d  = 1'b0;
      bad_d = 1'b0;
    end else if (st_q == C_RUN && chk_valid) begin
      cnt_d = cnt_q + SW'(1);
      bad_d = page_bad;
      if (cnt_q == '0) m0_d = nonff;
      if (last) begin
        if (page_bad || pg_q) begin
          rv_d = 1'b1;
          rb_d = page_bad;
          rp_d = pg_q;
          st_d = C_IDLE;
        end else begin
          pg_d  = 1'b1;
          cnt_d = '0;
          bad_d = 1'b0;
          m0_d  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= C_IDLE; big_q <= 1'b0; pg_q <= 1'b0; m0_q <= 1'b0;
      bad_q <= 1'b0; cnt_q <= '0; rv_q <= 1'b0; rb_q <= 1'b0; rp_q <= 1'b0;
    end else begin
      st_q <= st_d; big_q <= big_d; pg_q <= pg_d; m0_q <= m0_d;
      bad_q <= bad_d; cnt_q <= cnt_d; rv_q <= rv_d; rb_q <= rb_d; rp_q <= rp_d;
    end
  end

  assign res_valid = rv_q;
  assign res_bad   = rb_q;
  assign res_page  = rp_q;

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r9_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(chk_valid));
  a_r8_early_only_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_page) |-> res_bad);
endmodule

// File: rtl/spare_ecc_packer.sv
module spare_ecc_packer
  import spe_pkg::*;
#(
  parameter int SMALL_PAGE  = 512,
  parameter int BIG_PAGE    = 2048,
  parameter int SMALL_SPARE = 16,
  parameter int BIG_SPARE   = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       page_big,
  input  logic       prg_start,
  input  logic       prg_valid,
  input  logic [7:0] prg_data,
  output logic       spr_valid,
  output logic [7:0] spr_data,
  output logic       spr_last,
  input  logic       chk_start,
  input  logic       chk_valid,
  input  logic [7:0] chk_data,
  output logic       res_valid,
  output logic       res_bad,
  output logic       res_page
);
  localparam int CW     = $clog2(BIG_PAGE);
  localparam int SW     = $clog2(BIG_SPARE);
  localparam int SLOTS  = BIG_PAGE / CHUNK_BYTES;
  localparam int SLW    = CW - 8;
  localparam logic [CW-1:0] SMALL_PEND = CW'(SMALL_PAGE - 1);
  localparam logic [CW-1:0] BIG_PEND   = CW'(BIG_PAGE - 1);
  localparam logic [SW-1:0] SMALL_SEND = SW'(SMALL_SPARE - 1);
  localparam logic [SW-1:0] BIG_SEND   = SW'(BIG_SPARE - 1);
  localparam logic [SW-1:0] BIG_BASE   = SW'(BIG_SPARE - 3 * SLOTS);

  typedef enum logic [1:0] {P_IDLE, P_DATA, P_SPARE} pst_t;

  pst_t          st_q, st_d;
  logic          big_q, big_d;
  logic [CW-1:0] dcnt_q, dcnt_d;
  logic [SW-1:0] scnt_q, scnt_d;
  logic          accept, page_last, spare_last, start_ok, ecc_we;
  logic [SLW-1:0] slot;
  ecc_t          ecc_cur;
  ecc_t          ecc_mem [SLOTS];
  logic [SLOTS*24-1:0] ecc_flat;
  logic [7:0]    map_byte;

  always_comb begin
    start_ok   = (st_q == P_IDLE) && prg_start;
    accept     = (st_q == P_DATA) && prg_valid;
    page_last  = dcnt_q == (big_q ? BIG_PEND : SMALL_PEND);
    spare_last = scnt_q == (big_q ? BIG_SEND : SMALL_SEND);
    ecc_we     = accept && (dcnt_q[7:0] == 8'hFF);
    slot       = dcnt_q[CW-1:8];

    st_d   = st_q;
    big_d  = big_q;
    dcnt_d = dcnt_q;
    scnt_d = scnt_q;
    case (st_q)
      P_IDLE: if (prg_start) begin
        st_d   = P_DATA;
        big_d  = page_big;
        dcnt_d = '0;
      end
      P_DATA: if (prg_valid) begin
        dcnt_d = dcnt_q + CW'(1);
        if (page_last) begin
          st_d   = P_SPARE;
          scnt_d = '0;
        end
      end
      P_SPARE: begin
        scnt_d = scnt_q + SW'(1);
        if (spare_last) st_d = P_IDLE;
      end
      default: st_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= P_IDLE;
      big_q  <= 1'b0;
      dcnt_q <= '0;
      scnt_q <= '0;
    end else begin
      st_q   <= st_d;
      big_q  <= big_d;
      dcnt_q <= dcnt_d;
      scnt_q <= scnt_d;
    end
  end

  spe_ecc_chunk u_ecc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_ok),
    .en    (accept),
    .din   (prg_data),
    .pos   (dcnt_q[7:0]),
    .ecc_o (ecc_cur)
  );

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ecc_mem[k] <= '0;
      else if (ecc_we && slot == SLW'(k))
        ecc_mem[k] <= ecc_cur;
    end
    assign ecc_flat[k*24 +: 24] = ecc_mem[k];
  end

  spe_spare_map #(.SLOTS(SLOTS), .BIG_SPARE(BIG_SPARE)) u_map (
    .big      (big_q),
    .sidx     (scnt_q),
    .ecc_flat (ecc_flat),
    .byte_o   (map_byte)
  );

  assign spr_valid = st_q == P_SPARE;
  assign spr_data  = map_byte;
  assign spr_last  = spr_valid && spare_last;

  spe_bad_check #(.SMALL_SPARE(SMALL_SPARE), .BIG_SPARE(BIG_SPARE)) u_bad (
    .clk       (clk),
    .rst_n     (rst_n),
    .page_big  (page_big),
    .chk_start (chk_start),
    .chk_valid (chk_valid),
    .chk_data  (chk_data),
    .res_valid (res_valid),
    .res_bad   (res_bad),
    .res_page  (res_page)
  );

  a_r4_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_valid && !spr_last) |=> spr_valid);
  a_r4_first_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spr_valid) |-> $past(prg_valid));
  a_r2_small_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_valid && !big_q && (scnt_q == SW'(4) || scnt_q > SW'(7))) |-> spr_data == 8'hFF);
  a_r3_big_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_valid && big_q && scnt_q < BIG_BASE) |-> spr_data == 8'hFF);
endmodule

// File: tb/spare_ecc_packer_tb_top.sv
`timescale 1ns/1ps
module spare_ecc_packer_tb_top;
  logic clk, rst_n;
  logic page_big, prg_start, prg_valid, chk_start, chk_valid;
  logic [7:0] prg_data, chk_data, spr_data;
  logic spr_valid, spr_last, res_valid, res_bad, res_page;

  int n_chk, n_fail, cyc;
  logic [7:0] pg [0:2047];
  logic [7:0] exp_sp [0:63];
  logic [7:0] sp0 [0:63];
  logic [7:0] sp1 [0:63];

  spare_ecc_packer dut_i (
    .clk(clk), .rst_n(rst_n), .page_big(page_big),
    .prg_start(prg_start), .prg_valid(prg_valid), .prg_data(prg_data),
    .spr_valid(spr_valid), .spr_data(spr_data), .spr_last(spr_last),
    .chk_start(chk_start), .chk_valid(chk_valid), .chk_data(chk_data),
    .res_valid(res_valid), .res_bad(res_bad), .res_page(res_page)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R1 reference, written from the requirement text
  function automatic logic [23:0] ref_ecc(input int base);
    logic [7:0] l, m, b, e0, e1;
    logic [5:0] c;
    l = 0; m = 0; c = 0;
    for (int i = 0; i < 256; i++) begin
      b = pg[base + i];
      for (int j = 0; j < 8; j++) if (b[j]) begin
        c[j % 2] ^= 1'b1;
        c[2 + ((j / 2) % 2)] ^= 1'b1;
        c[4 + (j / 4)] ^= 1'b1;
      end
      if (^b) begin
        l ^= 8'(i);
        m ^= ~8'(i);
      end
    end
    for (int k = 0; k < 4; k++) begin
      e0[2*k+1] = ~l[k+4]; e0[2*k] = ~m[k+4];
      e1[2*k+1] = ~l[k];   e1[2*k] = ~m[k];
    end
    return {{~c, 2'b11}, e1, e0};
  endfunction

  function automatic void build_spare(input bit big);
    logic [23:0] e;
    int pos6 [6] = '{0, 1, 2, 3, 6, 7};
    for (int k = 0; k < 64; k++) exp_sp[k] = 8'hFF;
    for (int c = 0; c < (big ? 8 : 2); c++) begin
      e = ref_ecc(c * 256);
      for (int b = 0; b < 3; b++) begin
        if (big) exp_sp[40 + 3*c + b] = e[8*b +: 8];
        else     exp_sp[pos6[3*c + b]] = e[8*b +: 8];
      end
    end
  endfunction

  function automatic bit ref_bad(input bit big, input bit second);
    logic [7:0] a0, a1, a5;
    a0 = second ? sp1[0] : sp0[0];
    a1 = second ? sp1[1] : sp0[1];
    a5 = second ? sp1[5] : sp0[5];
    return big ? (a0 != 8'hFF && a1 != 8'hFF) : (a5 != 8'hFF);
  endfunction

  task automatic do_prog(input bit big, input int gap, input bit junk, input string req);
    int n, ns, i;
    bit early;
    n = big ? 2048 : 512; ns = big ? 64 : 16;
    build_spare(big);
    @(negedge clk);
    if (junk) begin  // R5: ignored before start
      for (int k = 0; k < 5; k++) begin
        prg_valid = 1'b1; prg_data = 8'($urandom);
        @(negedge clk);
      end
    end
    page_big = big; prg_start = 1'b1; prg_valid = 1'b0;
    @(negedge clk);
    prg_start = 1'b0;
    i = 0; early = 0;
    while (i < n) begin
      if (spr_valid) early = 1;
      if (int'($urandom % 100) < gap) prg_valid = 1'b0;
      else begin prg_valid = 1'b1; prg_data = pg[i]; i++; end
      @(negedge clk);
    end
    check(!early, "R4 no spare during data", early, 0);
    prg_valid = junk; prg_data = 8'($urandom);  // R5: ignored during spare
    for (int k = 0; k < ns; k++) begin
      check(spr_valid == 1'b1, "R4 spare valid", spr_valid, 1);
      check(spr_data == exp_sp[k], req, spr_data, exp_sp[k]);
      check(spr_last == (k == ns - 1), "R4 spare last", spr_last, (k == ns - 1));
      if (junk) prg_data = 8'($urandom);
      @(negedge clk);
    end
    prg_valid = 1'b0;
    check(spr_valid == 1'b0, "R4 spare ends", spr_valid, 0);
  endtask

  task automatic feed(input bit second, input int ns, output bit early);
    early = 0;
    for (int k = 0; k < ns; k++) begin
      chk_valid = 1'b1; chk_data = second ? sp1[k] : sp0[k];
      @(negedge clk);
      if (k < ns - 1 && res_valid) early = 1;
    end
    chk_valid = 1'b0;
  endtask

  task automatic do_chk(input bit big, input string req);
    int ns;
    bit early, b0, b1;
    ns = big ? 64 : 16;
    b0 = ref_bad(big, 0); b1 = ref_bad(big, 1);
    @(negedge clk);
    page_big = big; chk_start = 1'b1; chk_valid = 1'b0;
    @(negedge clk);
    chk_start = 1'b0;
    feed(0, ns, early);
    check(!early, "R9 no early verdict", early, 0);
    if (b0) begin
      check(res_valid == 1'b1, "R8 page0 verdict", res_valid, 1);
      check(res_bad == 1'b1 && res_page == 1'b0, req, {res_bad, res_page}, 2'b10);
      feed(1, ns, early);  // R8: page 1 ignored after early verdict
      check(!early && !res_valid, "R8 page1 ignored", early | res_valid, 0);
    end else begin
      check(res_valid == 1'b0, "R8 no verdict after good page0", res_valid, 0);
      feed(1, ns, early);
      check(!early, "R9 no early verdict p1", early, 0);
      check(res_valid == 1'b1, "R9 verdict due", res_valid, 1);
      check(res_bad == b1 && res_page == 1'b1, req, {res_bad, res_page}, {b1, 1'b1});
      @(negedge clk);
      check(res_valid == 1'b0, "R9 pulse one cycle", res_valid, 0);
    end
  endtask

  task automatic fill_sp(input int mode);
    for (int k = 0; k < 64; k++) begin
      sp0[k] = (mode == 0) ? 8'hFF : 8'($urandom);
      sp1[k] = (mode == 0) ? 8'hFF : 8'($urandom);
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int unsigned seed;
    bit hit;
    n_chk = 0; n_fail = 0;
    seed = $urandom(32'h5EED_1234);
    page_big = 0; prg_start = 0; prg_valid = 0; prg_data = 0;
    chk_start = 0; chk_valid = 0; chk_data = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(spr_valid == 1'b0, "R10 reset spr_valid", spr_valid, 0);
    check(res_valid == 1'b0, "R10 reset res_valid", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: scan bytes with no scan started
    hit = 0;
    for (int k = 0; k < 40; k++) begin
      chk_valid = 1'b1; chk_data = 8'h00;
      @(negedge clk);
      if (res_valid) hit = 1;
    end
    chk_valid = 1'b0;
    check(!hit, "R11 idle scan bytes ignored", hit, 0);

    // R1/R2 small pages
    for (int k = 0; k < 2048; k++) pg[k] = 8'hFF;
    do_prog(0, 0, 0, "R2 small all-FF");
    for (int k = 0; k < 2048; k++) pg[k] = 8'h00;
    do_prog(0, 0, 0, "R2 small all-zero");
    for (int t = 0; t < 3; t++) begin
      for (int k = 0; k < 2048; k++) pg[k] = 8'($urandom);
      do_prog(0, 20, t == 1, "R1 R2 small random");
    end
    // R1/R3 big pages, R5 junk
    for (int t = 0; t < 3; t++) begin
      for (int k = 0; k < 2048; k++) pg[k] = (t == 0) ? 8'(k) : 8'($urandom);
      do_prog(1, 10, t == 2, "R1 R3 big");
    end

    // R6 small marker
    fill_sp(0);                         do_chk(0, "R6 small good");
    fill_sp(0); sp0[5] = 8'h00;         do_chk(0, "R6 small page0 bad");
    fill_sp(0); sp1[5] = 8'h3C;         do_chk(0, "R6 small page1 bad");
    fill_sp(0); sp0[0] = 0; sp0[4] = 0; sp0[6] = 0; sp1[1] = 0;
                                        do_chk(0, "R6 other bytes ignored");
    // R7 big marker
    fill_sp(0); sp0[0] = 8'h00;         do_chk(1, "R7 big one byte good");
    fill_sp(0); sp0[1] = 8'h00; sp1[0] = 8'h12; do_chk(1, "R7 big split good");
    fill_sp(0); sp0[0] = 0; sp0[1] = 0; do_chk(1, "R7 big page0 bad");
    fill_sp(0); sp1[0] = 1; sp1[1] = 2; do_chk(1, "R7 R8 big page1 bad");
    for (int t = 0; t < 4; t++) begin
      fill_sp(1);
      if (t[0]) begin sp0[0] = 8'hFF; sp0[5] = 8'hFF; end
      do_chk(t[1], "R8 random scan");
    end

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule